// File: doc/BRIEF.md
# Dual-Thread Interrupt Controller with Shadow Masking

This block gathers 40 level-sensitive interrupt inputs and drives one request line to each of two hardware threads of a processor. Software reaches it through a small register bus. Enables for sources 0 to 31 sit in one 32-bit word, and enables for sources 32 to 39 sit in a second word. The pending state is readable through a matching pair of words. When a source is not paired, it reaches exactly one thread, chosen at elaboration time.

A source that must be visible to both threads is paired with a spare source number, its shadow. The target's own enable bit gates thread 0's copy of it. The enable bit of the shadow number gates thread 1's copy. The input wire of a shadow number is not an interrupt: its only job is to hold thread 1's enable for its partner. The pairing table is fixed by parameters. Requests follow the input levels and the enables directly, and nothing is latched.

Top module: `dual_thread_intc`

## Requirements
- R1: After reset, both enable words read back as zero and both request outputs stay low whatever the inputs, until software writes an enable word.
- R2: The low enable word is at byte offset 0x04. It is readable and writable, and bit n enables source n (1 = enabled).
- R3: The high enable word is at offset 0x50. Bit k (k = 0..7) enables source 32+k. Bits 31:8 read as zero and ignore writes.
- R4: Pending words are at 0x08 (bit n = source n) and 0x54 (bit k = source 32+k, bits 31:8 zero). An unpaired source's bit is input AND enable. A paired target's bit is input AND (own enable OR shadow's enable).
- R5: An unpaired source drives the request of exactly one thread: thread 1 when its bit of the thread-select parameter is 1, thread 0 otherwise. It never drives both.
- R6: For target T paired with shadow S, thread 0 sees T gated by enable bit T, and thread 1 sees T gated by enable bit S.
- R7: A shadow number's input never raises a request or a pending bit.
- R8: Requests are level-sensitive and combinational from the inputs and the stored enables. A request drops in the same cycle that its input falls, and drops right after the edge that clears its enable.
- R9: A read accepted at a clock edge returns, after that edge, the value of the addressed word at that edge. Unmapped offsets read as zero. The read data holds when no read is accepted.
- R10: Writes to the pending offsets or to unmapped offsets leave both enable words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | A bus access is presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irqIn | input | 40 | Level-sensitive interrupt inputs |
| irqOut | output | 2 | Request to thread 0 (bit 0) and thread 1 (bit 1) |

## Verification
Two things can land on the same clock edge: a bus access, and a change on an input level. The bench raises and drops a source on the negative edge just before a pending-word read is accepted, and in the cycle a shadow enable is rewritten. A behavioural model, evaluated on every clock, judges the result. The bench expects the read to capture the level present at the accepting edge and to hold afterwards. It expects the routed request to change with the input level or with the updated enable, and with no extra cycle of delay.

// File: rtl/dti_pkg.sv
package dti_pkg;

  localparam int MASK_LO_OFS = 'h04;
  localparam int PEND_LO_OFS = 'h08;
  localparam int MASK_HI_OFS = 'h50;
  localparam int PEND_HI_OFS = 'h54;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MASK_LO,
    RD_MASK_HI,
    RD_PEND_LO,
    RD_PEND_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrMaskLo;
    logic   wrMaskHi;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/dti_ctrl.sv
module dti_ctrl
  import dti_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);

  logic hitMaskLo, hitMaskHi, hitPendLo, hitPendHi;

  assign hitMaskLo = (busAddr == ADDR_W'(MASK_LO_OFS));
  assign hitMaskHi = (busAddr == ADDR_W'(MASK_HI_OFS));
  assign hitPendLo = (busAddr == ADDR_W'(PEND_LO_OFS));
  assign hitPendHi = (busAddr == ADDR_W'(PEND_HI_OFS));

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = RD_ZERO;
    strobes.wrMaskLo = busValid & busWrite & hitMaskLo;
    strobes.wrMaskHi = busValid & busWrite & hitMaskHi;
    strobes.rdEn     = busValid & ~busWrite;
    if (hitMaskLo)      strobes.rdSel = RD_MASK_LO;
    else if (hitMaskHi) strobes.rdSel = RD_MASK_HI;
    else if (hitPendLo) strobes.rdSel = RD_PEND_LO;
    else if (hitPendHi) strobes.rdSel = RD_PEND_HI;
  end

endmodule

// File: rtl/dti_router.sv
module dti_router #(
  parameter int                        NUM_SRC     = 40,
  parameter int                        IDX_W       = 8,
  parameter int                        NUM_PAIRS   = 2,
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_TARGET = {8'd38, 8'd30},
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_SHADOW = {8'd33, 8'd29},
  parameter logic [NUM_SRC-1:0]        THREAD_SEL  = 40'h80_0000_FF00
) (
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] maskBits,
  output logic [NUM_SRC-1:0] pendBits,
  output logic [NUM_SRC-1:0] thread0Bits,
  output logic [NUM_SRC-1:0] thread1Bits
);

  function automatic int shadowFor(input int src);
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (int'(PAIR_TARGET[p*IDX_W +: IDX_W]) == src)
        return int'(PAIR_SHADOW[p*IDX_W +: IDX_W]);
    end
    return -1;
  endfunction

  function automatic bit isShadowNum(input int src);
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (int'(PAIR_SHADOW[p*IDX_W +: IDX_W]) == src) return 1'b1;
    end
    return 1'b0;
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int SHD = shadowFor(i);
    if (isShadowNum(i)) begin : g_shadow
      logic unusedShadowIn;
      assign unusedShadowIn = irqIn[i] & maskBits[i];
      assign pendBits[i]    = 1'b0;
      assign thread0Bits[i] = 1'b0;
      assign thread1Bits[i] = 1'b0;
    end else if (SHD >= 0) begin : g_paired
      logic viewT0, viewT1;
      assign viewT0         = irqIn[i] & maskBits[i];
      assign viewT1         = irqIn[i] & maskBits[SHD];
      assign thread0Bits[i] = viewT0;
      assign thread1Bits[i] = viewT1;
      assign pendBits[i]    = viewT0 | viewT1;
    end else begin : g_single
      logic live;
      assign live           = irqIn[i] & maskBits[i];
      assign pendBits[i]    = live;
      assign thread0Bits[i] = THREAD_SEL[i] ? 1'b0 : live;
      assign thread1Bits[i] = THREAD_SEL[i] ? live : 1'b0;
    end
  end

endmodule

// File: rtl/dti_datapath.sv
module dti_datapath
  import dti_pkg::*;
#(
  parameter int                        NUM_SRC     = 40,
  parameter int                        WORD_W      = 32,
  parameter int                        IDX_W       = 8,
  parameter int                        NUM_PAIRS   = 2,
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_TARGET = {8'd38, 8'd30},
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_SHADOW = {8'd33, 8'd29},
  parameter logic [NUM_SRC-1:0]        THREAD_SEL  = 40'h80_0000_FF00
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [WORD_W-1:0] busRdata,
  output logic [1:0]        irqOut
);

  localparam int HI_W = NUM_SRC - WORD_W;

  logic [NUM_SRC-1:0] maskBits;
  logic [NUM_SRC-1:0] pendBits, thread0Bits, thread1Bits;
  logic [WORD_W-1:0]  rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      maskBits <= '0;
    end else begin
      if (strobes.wrMaskLo) maskBits[WORD_W-1:0]       <= busWdata;
      if (strobes.wrMaskHi) maskBits[NUM_SRC-1:WORD_W] <= busWdata[HI_W-1:0];
    end
  end

  dti_router #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .NUM_PAIRS(NUM_PAIRS),
    .PAIR_TARGET(PAIR_TARGET), .PAIR_SHADOW(PAIR_SHADOW), .THREAD_SEL(THREAD_SEL)
  ) u_router (
    .irqIn(irqIn), .maskBits(maskBits), .pendBits(pendBits),
    .thread0Bits(thread0Bits), .thread1Bits(thread1Bits)
  );

  assign irqOut = {|thread1Bits, |thread0Bits};

  always_comb begin
    case (strobes.rdSel)
      RD_MASK_LO: rdNext = maskBits[WORD_W-1:0];
      RD_MASK_HI: rdNext = {{(WORD_W-HI_W){1'b0}}, maskBits[NUM_SRC-1:WORD_W]};
      RD_PEND_LO: rdNext = pendBits[WORD_W-1:0];
      RD_PEND_HI: rdNext = {{(WORD_W-HI_W){1'b0}}, pendBits[NUM_SRC-1:WORD_W]};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               busRdata <= '0;
    else if (strobes.rdEn) busRdata <= rdNext;
  end

endmodule

// File: rtl/dual_thread_intc.sv
module dual_thread_intc
  import dti_pkg::*;
#(
  parameter int                        NUM_SRC     = 40,
  parameter int                        WORD_W      = 32,
  parameter int                        ADDR_W      = 8,
  parameter int                        IDX_W       = 8,
  parameter int                        NUM_PAIRS   = 2,
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_TARGET = {8'd38, 8'd30},
  parameter logic [NUM_PAIRS*IDX_W-1:0] PAIR_SHADOW = {8'd33, 8'd29},
  parameter logic [NUM_SRC-1:0]        THREAD_SEL  = 40'h80_0000_FF00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [1:0]         irqOut
);

  ctrlStrobes_t strobes;

  dti_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strobes(strobes)
  );

  dti_datapath #(
    .NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .IDX_W(IDX_W), .NUM_PAIRS(NUM_PAIRS),
    .PAIR_TARGET(PAIR_TARGET), .PAIR_SHADOW(PAIR_SHADOW), .THREAD_SEL(THREAD_SEL)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .busWdata(busWdata),
    .irqIn(irqIn), .busRdata(busRdata), .irqOut(irqOut)
  );

endmodule

// File: rtl/dti_checker.sv
module dti_checker
  import dti_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [WORD_W-1:0]  busWdata,
  input logic [WORD_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [1:0]         irqOut
);

  localparam int HI_W = NUM_SRC - WORD_W;

  logic maskTouched;
  logic rdAcc, enWrite;
  logic unusedWdata;

  assign rdAcc       = busValid & ~busWrite;
  assign enWrite     = busValid & busWrite &
                       (busAddr == ADDR_W'(MASK_LO_OFS) || busAddr == ADDR_W'(MASK_HI_OFS));
  assign unusedWdata = ^busWdata;

  always_ff @(posedge clk) begin
    if (rst)          maskTouched <= 1'b0;
    else if (enWrite) maskTouched <= 1'b1;
  end

  // R1: no request until software has written an enable word
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !maskTouched |-> (irqOut == 2'b00));

  // R3: unused high enable bits read as zero
  p_mask_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rdAcc && busAddr == ADDR_W'(MASK_HI_OFS)) |=> (busRdata[WORD_W-1:HI_W] == '0));

  // R4: a low pending bit is never set without its input level
  p_pend_needs_level_r4: assert property (@(posedge clk) disable iff (rst)
    (rdAcc && busAddr == ADDR_W'(PEND_LO_OFS)) |=>
      ((busRdata & ~$past(irqIn[WORD_W-1:0])) == '0));

  // R8: a request needs some input high
  p_no_phantom_r8: assert property (@(posedge clk) disable iff (rst)
    (|irqOut) |-> (|irqIn));

  // R9: read data holds when no read is accepted
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rdAcc |=> $stable(busRdata));

endmodule

bind dual_thread_intc dti_checker #(
  .NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) u_dtiChk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .irqIn(irqIn), .irqOut(irqOut)
);

// File: tb/dual_thread_intc_test.sv
`timescale 1ns/100ps
module dual_thread_intc_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [39:0] irqIn = '0;
  logic [1:0]  irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dual_thread_intc uut (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  // Reference model: pairs 30<-29 and 38<-33; thread 1 owns 8..15 and 39
  int shdOf[40];
  bit isShd[40];
  bit selT1[40];
  bit mMask[40];
  logic [31:0] mRd;

  initial begin
    for (int i = 0; i < 40; i++) begin
      shdOf[i] = -1; isShd[i] = 0; mMask[i] = 0;
      selT1[i] = (i >= 8 && i <= 15) || i == 39;
    end
    shdOf[30] = 29; isShd[29] = 1;
    shdOf[38] = 33; isShd[33] = 1;
  end

  function automatic logic [39:0] modelPend();
    logic [39:0] p = '0;
    for (int i = 0; i < 40; i++) begin
      if (isShd[i]) p[i] = 0;
      else if (shdOf[i] >= 0) p[i] = irqIn[i] & (mMask[i] | mMask[shdOf[i]]);
      else p[i] = irqIn[i] & mMask[i];
    end
    return p;
  endfunction

  function automatic logic [1:0] modelIrq();
    logic [1:0] r = '0;
    for (int i = 0; i < 40; i++) begin
      if (isShd[i]) continue;
      if (shdOf[i] >= 0) begin
        r[0] |= irqIn[i] & mMask[i];
        r[1] |= irqIn[i] & mMask[shdOf[i]];
      end else if (selT1[i]) r[1] |= irqIn[i] & mMask[i];
      else r[0] |= irqIn[i] & mMask[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [39:0] p = modelPend();
    logic [31:0] v = '0;
    case (a)
      8'h04: for (int i = 0; i < 32; i++) v[i] = mMask[i];
      8'h50: for (int i = 0; i < 8; i++)  v[i] = mMask[32+i];
      8'h08: v = p[31:0];
      8'h54: v = {24'h0, p[39:32]};
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mRd = '0;
      for (int i = 0; i < 40; i++) mMask[i] = 0;
    end else if (busValid && !busWrite) begin
      mRd = modelRead(busAddr);
    end else if (busValid && busWrite) begin
      if (busAddr == 8'h04) for (int i = 0; i < 32; i++) mMask[i] = busWdata[i];
      if (busAddr == 8'h50) for (int i = 0; i < 8; i++)  mMask[32+i] = busWdata[i];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk); #1;
    if (!rst && !done) begin
      chk("R5 R6 R8 cycle irqOut", {30'h0, irqOut}, {30'h0, modelIrq()});
      chk("R9 cycle busRdata", busRdata, mRd);
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    #1;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
    #1;
    d = busRdata;
  endtask

  task automatic setIn(input logic [39:0] v);
    @(negedge clk);
    irqIn = v;
    #1;
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    setIn({40{1'b1}});
    chk("R1 irq after reset", {30'h0, irqOut}, 32'h0);
    busRd(8'h04, rd); chk("R1 mask lo after reset", rd, 32'h0);
    busRd(8'h50, rd); chk("R1 mask hi after reset", rd, 32'h0);
    setIn('0);
    // R2, R3 enable words
    busWr(8'h04, 32'hFFFF_FFFF);
    busRd(8'h04, rd); chk("R2 mask lo readback", rd, 32'hFFFF_FFFF);
    busWr(8'h50, 32'hFFFF_FFFF);
    busRd(8'h50, rd); chk("R3 mask hi readback", rd, 32'h0000_00FF);
    // R10 ignored writes, R9 unmapped read
    busWr(8'h08, 32'h0); busWr(8'h54, 32'h0); busWr(8'h20, 32'h0);
    busRd(8'h04, rd); chk("R10 mask lo kept", rd, 32'hFFFF_FFFF);
    busRd(8'h50, rd); chk("R10 mask hi kept", rd, 32'h0000_00FF);
    busRd(8'h20, rd); chk("R9 unmapped read", rd, 32'h0);
    // R5 routing of unpaired sources
    setIn(40'h1 << 3);  chk("R5 src3 thread0", {30'h0, irqOut}, 32'h1);
    busRd(8'h08, rd);   chk("R4 pend lo src3", rd, 32'h8);
    setIn(40'h1 << 10); chk("R5 src10 thread1", {30'h0, irqOut}, 32'h2);
    setIn(40'h1 << 39); chk("R5 src39 thread1", {30'h0, irqOut}, 32'h2);
    busRd(8'h54, rd);   chk("R4 pend hi src39", rd, 32'h80);
    // R7 shadow input ignored
    setIn((40'h1 << 29) | (40'h1 << 33));
    chk("R7 shadow irq", {30'h0, irqOut}, 32'h0);
    busRd(8'h08, rd); chk("R7 shadow pend lo", rd, 32'h0);
    busRd(8'h54, rd); chk("R7 shadow pend hi", rd, 32'h0);
    // R6 paired target 30 / shadow 29
    setIn(40'h1 << 30); chk("R6 both threads", {30'h0, irqOut}, 32'h3);
    busWr(8'h04, ~(32'h1 << 29)); chk("R6 shadow off", {30'h0, irqOut}, 32'h1);
    busWr(8'h04, ~(32'h1 << 30)); chk("R6 own off", {30'h0, irqOut}, 32'h2);
    busRd(8'h08, rd); chk("R4 paired pend via shadow", rd, 32'h4000_0000);
    busWr(8'h04, ~((32'h1 << 30) | (32'h1 << 29)));
    chk("R6 both off", {30'h0, irqOut}, 32'h0);
    busRd(8'h08, rd); chk("R4 paired pend off", rd, 32'h0);
    // R6 paired target 38 / shadow 33 in high word
    setIn(40'h1 << 38);
    busWr(8'h50, 32'h02); chk("R6 hi shadow only", {30'h0, irqOut}, 32'h2);
    busWr(8'h50, 32'h40); chk("R6 hi own only", {30'h0, irqOut}, 32'h1);
    // R8 level behaviour
    busWr(8'h04, 32'hFFFF_FFFF);
    setIn(40'h1 << 3); chk("R8 level high", {30'h0, irqOut}, 32'h1);
    setIn('0);         chk("R8 level drop", {30'h0, irqOut}, 32'h0);
    setIn(40'h1 << 3);
    busWr(8'h04, 32'h0); chk("R8 enable cleared", {30'h0, irqOut}, 32'h0);
    // R9 read captures level at accept edge, then holds
    busWr(8'h04, 32'h20);
    setIn(40'h1 << 5);
    busRd(8'h08, rd); chk("R9 pend capture", rd, 32'h20);
    setIn('0); setIn('0);
    chk("R9 pend hold", busRdata, 32'h20);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule